// File: doc/BRIEF.md
# System Reset Sequencer

This block merges every reset cause of a small microcontroller into one system reset. Its inputs are an active-low external reset pin, single-cycle strobes for power-on, brown-out and watchdog events, a write strobe that sets a debugger reset request, and a stop-mode recovery strobe. The raw pin passes through a two-flop synchronizer. It is then qualified against a minimum low time, so short glitches are ignored. Each accepted cause loads a per-source time-out counter. The system reset and the open-drain pin pull-down stay active until that count runs out and the pin is no longer held low.

Stop-mode recovery is handled differently. It holds only the CPU in reset for a short fixed count, leaves the system reset alone, and forces the oscillator control to the internal oscillator, selected and enabled. A sticky status vector records every cause that fired. Software clears it with a read-clear strobe. A debugger-requested reset runs as a full power-on-class reset but leaves the debug block's own reset low. The debug block's reset is asserted only for power-related causes.

Status bit positions: bit 0 power-on (also set by a debugger reset), bit 1 brown-out, bit 2 watchdog, bit 3 external pin, bit 4 stop recovery. The oscillator control word is {enable, select-internal}.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The system reset is accepted only after the synchronized pin reads low on QUAL consecutive clock edges (default 3). `sys_rst_o` rises after the edge that comes QUAL+1 edges after the first edge sampling the pin low. A low pulse sampled on fewer edges has no effect.
- R2: While the synchronized pin stays low after qualification, `sys_rst_o` stays high, however long that lasts.
- R3: Once the time-out has expired, `sys_rst_o` falls at the second clock edge after the first edge that samples the pin high again.
- R4: A pin-caused reset sets status bit 3.
- R5: A power-on, brown-out or watchdog strobe raises `sys_rst_o` and `pin_drive_low_o` on the next cycle. Both then stay high for exactly POR_DLY, BO_DLY or WDT_DLY cycles (defaults 16, 12, 8). A pin-caused reset uses EXT_DLY (default 6). After block reset, `sys_rst_o` is low.
- R6: Outside reset, `pin_drive_low_o` follows `gpio_drv_en_i` one cycle late.
- R7: A pulse on `dbg_rst_wr_i` makes `dbg_req_o` read 1 for one cycle, after which it clears itself. In the cycle after that, a reset of POR_DLY cycles begins and status bit 0 is set. `dbg_rst_o` stays low throughout.
- R8: A stop-recovery strobe holds `cpu_rst_o` high for exactly STOP_CYC cycles (default 4). It sets status bit 4 and leaves `sys_rst_o`, `dbg_rst_o` and the other status bits unchanged.
- R9: After block reset and after every stop recovery, the oscillator word reads 2'b11. Otherwise `osc_wr_i` loads it, and a stop strobe in the same cycle takes precedence.
- R10: A new cause arriving during an active time-out restarts the count with that cause's delay.
- R11: When several causes strobe together, all of their status bits are set and the time-out uses the longest of their delays.
- R12: Status bits are cleared only by `stat_rd_clr_i` and are not affected by reset release. A set in the same cycle as a clear wins. After block reset the vector reads 0.
- R13: `dbg_rst_o` is high only during resets that include a power-on or brown-out cause, for the full span of that system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block initialisation |
| rst_pin_n_i | input | 1 | Raw reset pin level, active low, asynchronous |
| por_evt_i | input | 1 | Power-on event strobe |
| bo_evt_i | input | 1 | Brown-out event strobe |
| wdt_evt_i | input | 1 | Watchdog time-out strobe |
| dbg_rst_wr_i | input | 1 | Debugger writes 1 to its reset request bit |
| stop_rcv_i | input | 1 | Stop-mode recovery strobe |
| gpio_drv_en_i | input | 1 | Port logic request to drive the pin low |
| stat_rd_clr_i | input | 1 | Software read-clear of the status vector |
| osc_wr_i | input | 1 | Software write of the oscillator word |
| osc_wdata_i | input | 2 | Oscillator word {enable, select-internal} |
| pin_drive_low_o | output | 1 | Open-drain pull-down enable for the pin |
| sys_rst_o | output | 1 | System reset to all registers |
| cpu_rst_o | output | 1 | CPU reset (system reset or stop recovery) |
| dbg_rst_o | output | 1 | Debug block reset |
| dbg_req_o | output | 1 | Debugger reset request bit |
| rst_stat_o | output | 5 | Sticky cause flags |
| osc_int_sel_o | output | 1 | Internal oscillator selected as clock |
| osc_int_en_o | output | 1 | Internal oscillator enabled |

## Verification
The bench aims at the pin qualification edge. A pulse sampled on two edges must leave no trace, and one sampled on three must start a reset. A counter that did not clear on a high sample, or that missed the synchronizer latency, would show up as a reset one cycle early or late, or as a spurious external flag. It also retriggers the watchdog partway through its time-out and strobes two causes at once. A design that kept the old count or picked the wrong delay would end the reset at the wrong cycle. Finally it checks that a debugger reset leaves the debug block reset low, and that stop recovery moves only the CPU reset, the stop flag and the oscillator word. A design that leaked into the system reset would be caught in the cycle where it happens.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // status vector bit positions (software decodes these)
  localparam int ST_POR  = 0;
  localparam int ST_BO   = 1;
  localparam int ST_WDT  = 2;
  localparam int ST_EXT  = 3;
  localparam int ST_STOP = 4;
  localparam int ST_W    = 5;

  // time-out request lanes
  localparam int EV_POR = 0;
  localparam int EV_BO  = 1;
  localparam int EV_WDT = 2;
  localparam int EV_EXT = 3;
  localparam int EV_N   = 4;

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic pin_sync_o,
  output logic hit_o,
  output logic active_o
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL);
  localparam logic [CW-1:0] QM1  = CW'(QUAL - 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= pin_n_i;
      sync_q <= meta_q;
      if (sync_q)
        run_q <= '0;
      else if (run_q != QMAX)
        run_q <= run_q + 1'b1;
    end
  end

  assign pin_sync_o = sync_q;
  assign hit_o      = !sync_q && (run_q == QM1);
  assign active_o   = !sync_q && (run_q >= QM1);

  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o); // R1

endmodule

// File: rtl/rst_timeout.sv
module rst_timeout #(
  parameter int NEV = 4,
  parameter int TW  = 4,
  parameter logic [NEV*TW-1:0] DLY_VEC = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev_i,
  input  logic           pwr_ev_i,
  input  logic           hold_i,
  output logic           in_rst_o,
  output logic           pwr_o
);
  logic          in_rst_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] load_val;
  logic          any_ev;
  logic          release_now;
  logic          pwr_q;

  always_comb begin
    load_val = '0;
    for (int i = 0; i < NEV; i++) begin
      if (ev_i[i] && (DLY_VEC[i*TW +: TW] > load_val))
        load_val = DLY_VEC[i*TW +: TW];
    end
  end

  assign any_ev      = |ev_i;
  assign release_now = in_rst_q && !any_ev && (tmr_q == '0) && !hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rst_q <= 1'b0;
      tmr_q    <= '0;
    end else if (any_ev) begin
      in_rst_q <= 1'b1;
      tmr_q    <= load_val;
    end else if (in_rst_q) begin
      if (tmr_q != '0)
        tmr_q <= tmr_q - 1'b1;
      else if (!hold_i)
        in_rst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pwr_q <= 1'b0;
    else if (pwr_ev_i)
      pwr_q <= 1'b1;
    else if (release_now)
      pwr_q <= 1'b0;
  end

  assign in_rst_o = in_rst_q;
  assign pwr_o    = pwr_q;

  AST_EVENT_STARTS: assert property (@(posedge clk) disable iff (rst)
    any_ev |=> in_rst_q); // R5
  AST_RELEASE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(in_rst_q) |-> !$past(hold_i)); // R3
  AST_PWR_INSIDE: assert property (@(posedge clk) disable iff (rst)
    pwr_q |-> in_rst_q); // R13

endmodule

// File: rtl/rst_stop_hold.sv
module rst_stop_hold #(
  parameter int STOP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_i,
  output logic hold_o
);
  localparam int SW = rst_seq_pkg::bits_for(STOP_CYC);
  localparam logic [SW-1:0] LOADV = SW'(STOP_CYC - 1);

  logic          act_q;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      act_q <= 1'b1;
      cnt_q <= LOADV;
    end else if (act_q) begin
      if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      else
        act_q <= 1'b0;
    end
  end

  assign hold_o = act_q;

  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(stop_i)); // R8

endmodule

// File: rtl/rst_status.sv
module rst_status #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic          clr_i,
  input  logic          stop_i,
  input  logic          osc_wr_i,
  input  logic [1:0]    osc_d_i,
  output logic [NB-1:0] flags_o,
  output logic [1:0]    osc_o
);
  logic [NB-1:0] flag_q;
  logic [1:0]    osc_q;

  for (genvar gi = 0; gi < NB; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[gi] <= 1'b0;
      else if (set_i[gi])
        flag_q[gi] <= 1'b1;
      else if (clr_i)
        flag_q[gi] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      osc_q <= 2'b11;
    else if (stop_i)
      osc_q <= 2'b11;
    else if (osc_wr_i)
      osc_q <= osc_d_i;
  end

  assign flags_o = flag_q;
  assign osc_o   = osc_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R12
  AST_OSC_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (osc_q == 2'b11)); // R9

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int QUAL     = 3,
  parameter int POR_DLY  = 16,
  parameter int BO_DLY   = 12,
  parameter int WDT_DLY  = 8,
  parameter int EXT_DLY  = 6,
  parameter int STOP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin_n_i,
  input  logic       por_evt_i,
  input  logic       bo_evt_i,
  input  logic       wdt_evt_i,
  input  logic       dbg_rst_wr_i,
  input  logic       stop_rcv_i,
  input  logic       gpio_drv_en_i,
  input  logic       stat_rd_clr_i,
  input  logic       osc_wr_i,
  input  logic [1:0] osc_wdata_i,
  output logic       pin_drive_low_o,
  output logic       sys_rst_o,
  output logic       cpu_rst_o,
  output logic       dbg_rst_o,
  output logic       dbg_req_o,
  output logic [4:0] rst_stat_o,
  output logic       osc_int_sel_o,
  output logic       osc_int_en_o
);
  import rst_seq_pkg::*;

  localparam int MAXD = umax(umax(POR_DLY, BO_DLY), umax(WDT_DLY, EXT_DLY));
  localparam int TW   = bits_for(MAXD);
  localparam logic [EV_N*TW-1:0] DLY_VEC = {TW'(EXT_DLY - 1), TW'(WDT_DLY - 1),
                                            TW'(BO_DLY - 1),  TW'(POR_DLY - 1)};

  logic              pin_sync;
  logic              ext_hit;
  logic              ext_act;
  logic              dbg_req_q;
  logic              gpio_q;
  logic [EV_N-1:0]   ev;
  logic [ST_W-1:0]   stat_set;
  logic              in_rst;
  logic              pwr_rst;
  logic              stop_hold;
  logic [1:0]        osc_word;

  rst_pin_qual #(.QUAL(QUAL)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .pin_n_i    (rst_pin_n_i),
    .pin_sync_o (pin_sync),
    .hit_o      (ext_hit),
    .active_o   (ext_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_req_q <= 1'b0;
      gpio_q    <= 1'b0;
    end else begin
      dbg_req_q <= dbg_rst_wr_i;
      gpio_q    <= gpio_drv_en_i;
    end
  end

  always_comb begin
    ev         = '0;
    ev[EV_POR] = por_evt_i | dbg_req_q;
    ev[EV_BO]  = bo_evt_i;
    ev[EV_WDT] = wdt_evt_i;
    ev[EV_EXT] = ext_hit;
    stat_set          = '0;
    stat_set[ST_POR]  = por_evt_i | dbg_req_q;
    stat_set[ST_BO]   = bo_evt_i;
    stat_set[ST_WDT]  = wdt_evt_i;
    stat_set[ST_EXT]  = ext_hit;
    stat_set[ST_STOP] = stop_rcv_i;
  end

  rst_timeout #(.NEV(EV_N), .TW(TW), .DLY_VEC(DLY_VEC)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev),
    .pwr_ev_i (por_evt_i | bo_evt_i),
    .hold_i   (ext_act),
    .in_rst_o (in_rst),
    .pwr_o    (pwr_rst)
  );

  rst_stop_hold #(.STOP_CYC(STOP_CYC)) u_stop (
    .clk    (clk),
    .rst    (rst),
    .stop_i (stop_rcv_i),
    .hold_o (stop_hold)
  );

  rst_status #(.NB(ST_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (stat_set),
    .clr_i    (stat_rd_clr_i),
    .stop_i   (stop_rcv_i),
    .osc_wr_i (osc_wr_i),
    .osc_d_i  (osc_wdata_i),
    .flags_o  (rst_stat_o),
    .osc_o    (osc_word)
  );

  assign sys_rst_o       = in_rst;
  assign cpu_rst_o       = in_rst | stop_hold;
  assign pin_drive_low_o = in_rst | gpio_q;
  assign dbg_rst_o       = pwr_rst;
  assign dbg_req_o       = dbg_req_q;
  assign osc_int_sel_o   = osc_word[0];
  assign osc_int_en_o    = osc_word[1];

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ext_act |=> sys_rst_o); // R2
  AST_RELEASE_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> $past(pin_sync)); // R3
  AST_SRC_DRIVES_PIN: assert property (@(posedge clk) disable iff (rst)
    (por_evt_i | bo_evt_i | wdt_evt_i) |=> (sys_rst_o && pin_drive_low_o)); // R5
  AST_DBG_KEEPS_DEBUG: assert property (@(posedge clk) disable iff (rst)
    (dbg_req_o && !por_evt_i && !bo_evt_i && !dbg_rst_o) |=> (sys_rst_o && !dbg_rst_o)); // R7
  AST_STOP_CPU_ONLY: assert property (@(posedge clk) disable iff (rst)
    (stop_rcv_i && !sys_rst_o && !(|ev)) |=> (!sys_rst_o && cpu_rst_o)); // R8

endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;
  localparam int QUAL = 3, POR_DLY = 16, BO_DLY = 12, WDT_DLY = 8, EXT_DLY = 6, STOP_CYC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic pin_n = 1'b1, por = 1'b0, bo = 1'b0, wdt = 1'b0, dbg_wr = 1'b0, stop = 1'b0;
  logic gpio = 1'b0, clr = 1'b0, osc_wr = 1'b0;
  logic [1:0] osc_d = 2'b00;
  logic pin_drv, sys_rst, cpu_rst, dbg_rst, dbg_req, osc_sel, osc_en;
  logic [4:0] stat;

  rst_seq_ctrl #(.QUAL(QUAL), .POR_DLY(POR_DLY), .BO_DLY(BO_DLY), .WDT_DLY(WDT_DLY),
                 .EXT_DLY(EXT_DLY), .STOP_CYC(STOP_CYC)) dut_i (
    .clk(clk), .rst(rst), .rst_pin_n_i(pin_n), .por_evt_i(por), .bo_evt_i(bo),
    .wdt_evt_i(wdt), .dbg_rst_wr_i(dbg_wr), .stop_rcv_i(stop), .gpio_drv_en_i(gpio),
    .stat_rd_clr_i(clr), .osc_wr_i(osc_wr), .osc_wdata_i(osc_d),
    .pin_drive_low_o(pin_drv), .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst),
    .dbg_rst_o(dbg_rst), .dbg_req_o(dbg_req), .rst_stat_o(stat),
    .osc_int_sel_o(osc_sel), .osc_int_en_o(osc_en));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit pq[$];
  int low_run, rem, stop_rem, ld;
  bit in_m, pwr_m, dreq_m, gp_m, s2, hit, act, anyev;
  bit [4:0] st_m, newb;
  bit [1:0] osc_m;

  always @(posedge clk) begin
    if (rst) begin
      pq.delete(); pq.push_back(1'b1); pq.push_back(1'b1);
      low_run = 0; rem = 0; stop_rem = 0;
      in_m = 0; pwr_m = 0; dreq_m = 0; gp_m = 0; st_m = '0; osc_m = 2'b11;
    end else begin
      s2  = pq[0];
      hit = !s2 && (low_run == QUAL - 1);
      act = !s2 && (low_run >= QUAL - 1);
      if (s2) low_run = 0; else if (low_run < QUAL) low_run++;
      ld = 0; anyev = 0;
      if (por || dreq_m) begin anyev = 1; if (POR_DLY > ld) ld = POR_DLY; end
      if (bo)            begin anyev = 1; if (BO_DLY  > ld) ld = BO_DLY;  end
      if (wdt)           begin anyev = 1; if (WDT_DLY > ld) ld = WDT_DLY; end
      if (hit)           begin anyev = 1; if (EXT_DLY > ld) ld = EXT_DLY; end
      if (anyev) begin in_m = 1; rem = ld; end
      else if (in_m) begin
        if (rem > 1) rem--;
        else if (!act) in_m = 0;
      end
      if (por || bo) pwr_m = 1; else if (!in_m) pwr_m = 0;
      newb = {stop, hit, wdt, bo, por || dreq_m};
      if (clr) st_m = '0;
      st_m = st_m | newb;
      dreq_m = dbg_wr;
      if (stop) stop_rem = STOP_CYC; else if (stop_rem > 0) stop_rem--;
      if (stop) osc_m = 2'b11; else if (osc_wr) osc_m = osc_d;
      gp_m = gpio;
      void'(pq.pop_front()); pq.push_back(pin_n);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 sys_rst_o", sys_rst, in_m);
      chk("R8 cpu_rst_o", cpu_rst, in_m || (stop_rem > 0));
      chk("R6 pin_drive_low_o", pin_drv, in_m || gp_m);
      chk("R13 dbg_rst_o", dbg_rst, pwr_m);
      chk("R7 dbg_req_o", dbg_req, dreq_m);
      chk("R12 rst_stat_o", stat, st_m);
      chk("R9 osc word", {osc_en, osc_sel}, osc_m);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic count_sys(output int n);
    n = 0;
    while (sys_rst && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic count_cpu(output int n);
    n = 0;
    while (cpu_rst && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk("R5 reset sys", sys_rst, 0);
    chk("R12 reset stat", stat, 0);
    chk("R9 reset osc", {osc_en, osc_sel}, 3);
    chk("R6 reset pin", pin_drv, 0);

    // power-on reset length and debug block reset
    por = 1'b1; tick(); por = 1'b0;
    chk("R13 dbg_rst on power-on", dbg_rst, 1);
    chk("R12 por flag", stat, 5'b00001);
    count_sys(n);
    chk("R5 power-on length", n, POR_DLY);
    chk("R12 flag survives release", stat, 5'b00001);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R12 read-clear", stat, 0);

    // short pin pulse: two samples low
    pin_n = 1'b0; tick(); tick(); pin_n = 1'b1;
    repeat (8) tick();
    chk("R1 short pulse no flag", stat, 0);
    chk("R1 short pulse no reset", sys_rst, 0);

    // long pin low
    pin_n = 1'b0;
    repeat (4) tick();
    chk("R1 not yet", sys_rst, 0);
    tick();
    chk("R1 qualified", sys_rst, 1);
    chk("R5 pin driven", pin_drv, 1);
    repeat (15) tick();
    chk("R2 held while low", sys_rst, 1);
    pin_n = 1'b1;
    tick(); tick();
    chk("R2 still held", sys_rst, 1);
    tick();
    chk("R3 released", sys_rst, 0);
    chk("R4 ext flag", stat, 5'b01000);
    clr = 1'b1; tick(); clr = 1'b0;

    // gpio drive outside reset
    gpio = 1'b1; tick();
    chk("R6 gpio drive", pin_drv, 1);
    chk("R6 no reset", sys_rst, 0);
    gpio = 1'b0; tick();
    chk("R6 gpio off", pin_drv, 0);

    // debugger reset
    dbg_wr = 1'b1; tick(); dbg_wr = 1'b0;
    chk("R7 request bit", dbg_req, 1);
    chk("R7 not yet", sys_rst, 0);
    tick();
    chk("R7 bit self-clears", dbg_req, 0);
    chk("R7 reset started", sys_rst, 1);
    chk("R7 debug block untouched", dbg_rst, 0);
    count_sys(n);
    chk("R7 length", n, POR_DLY);
    chk("R7 por flag", stat, 5'b00001);
    clr = 1'b1; tick(); clr = 1'b0;

    // retrigger
    wdt = 1'b1; tick(); wdt = 1'b0;
    repeat (4) tick();
    wdt = 1'b1; tick(); wdt = 1'b0;
    count_sys(n);
    chk("R10 restarted count", n, WDT_DLY);

    // simultaneous causes
    clr = 1'b1; tick(); clr = 1'b0;
    wdt = 1'b1; bo = 1'b1; tick(); wdt = 1'b0; bo = 1'b0;
    chk("R11 both flags", stat, 5'b00110);
    chk("R13 dbg_rst on brown-out", dbg_rst, 1);
    count_sys(n);
    chk("R11 longest delay", n, BO_DLY);
    clr = 1'b1; tick(); clr = 1'b0;

    // stop recovery
    osc_wr = 1'b1; osc_d = 2'b00; tick(); osc_wr = 1'b0;
    chk("R9 software write", {osc_en, osc_sel}, 0);
    wdt = 1'b1; tick(); wdt = 1'b0;
    count_sys(n);
    stop = 1'b1; osc_wr = 1'b1; osc_d = 2'b01; tick(); stop = 1'b0; osc_wr = 1'b0;
    chk("R8 cpu held", cpu_rst, 1);
    chk("R8 sys untouched", sys_rst, 0);
    chk("R8 dbg untouched", dbg_rst, 0);
    chk("R9 forced internal", {osc_en, osc_sel}, 3);
    chk("R8 flags", stat, 5'b10100);
    count_cpu(n);
    chk("R8 stop length", n, STOP_CYC);

    // set beats clear
    clr = 1'b1; wdt = 1'b1; tick(); clr = 1'b0; wdt = 1'b0;
    chk("R12 set wins", stat, 5'b00100);
    count_sys(n);
    repeat (3) tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule